// File: doc/BRIEF.md
# Serial Pixel Lane Deserializer

This block sits at the receiving end of a narrow serial video link. It takes one, two or three serial data lanes, a bit-rate clock and a pixel-rate reference, and rebuilds one 30-bit pixel word per reference period. The word carries 24 colour bits, horizontal sync, vertical sync, data-enable, two auxiliary bits and an even-parity bit. A two-bit lane-mode input sets how many lanes carry data, and it must match the sending side. The bit clock is supplied from outside, so this block does not recover a clock.

Each rising edge of the reference starts a new pixel. The block shifts in one bit per active lane on every bit-clock cycle. When the last slot arrives, the colour, sync and auxiliary fields are registered together with a parity-error flag. The parity check leaves out the auxiliary bits. A monitor counts bit-clock cycles between reference edges. When the reference goes quiet, the monitor puts the block into standby and blanks the outputs. It brings the block back once the reference is toggling again.

Top module: `pixel_deser`

## Requirements
- R1: While reset is asserted, and right after it is released, all colour, sync, aux, `par_err`, `pix_clk_out` and `standby` outputs are low.
- R2: The number of active lanes N is set by `lane_mode`: 00 gives 1 lane, 01 gives 2, 10 gives 3, and 11 gives 1. A pixel lasts 30/N bit clocks. In slot s of the pixel, lane k carries word bit 29-(s*N+k). The word bits are 29 parity, 28 DE, 27 VS, 26 HS, 25:18 red, 17:10 green, 9:2 blue and 1:0 aux.
- R3: `lane_mode` is sampled on the cycle of the reference's rising edge and held for the whole pixel. A change later in the pixel has no effect on that pixel.
- R4: The fields and `par_err` update together at the clock edge that captures a pixel's last slot. They then hold until the next pixel completes, so `par_err` stays high for one whole pixel per bad pixel.
- R5: Parity is even over bits 29..2. `par_err` is the XOR of those 28 bits, and the aux bits never affect it.
- R6: A rising edge of `pix_ref` restarts word assembly at slot 0 and drops any partial word. Only words that received all of their slots after a rising edge are delivered.
- R7: After 64 consecutive bit-clock cycles with no rising edge on `pix_ref`, `standby` goes high. While `standby` is high, the fields, `par_err` and `pix_clk_out` are held low.
- R8: In standby, the third rising edge of `pix_ref` clears `standby`. A new 64-cycle quiet gap during standby restarts this edge count.
- R9: The first complete word after reset, and the first after leaving standby, is discarded, so the outputs keep their previous (low) values.
- R10: Outside standby, `pix_clk_out` equals `pix_ref` delayed by one bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_mode | input | 2 | Active lane count select |
| lane_data | input | 3 | Serial lane inputs, lane 0 in bit 0 |
| pix_ref | input | 1 | Pixel-rate reference; a rising edge starts a pixel |
| red | output | 8 | Red field |
| grn | output | 8 | Green field |
| blu | output | 8 | Blue field |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| den | output | 1 | Data enable |
| aux | output | 2 | Auxiliary bits |
| pix_clk_out | output | 1 | Regenerated pixel clock |
| par_err | output | 1 | Parity error for the last delivered pixel |
| standby | output | 1 | Reference-loss standby indicator |

## Verification
Bad state in the shift register or slot counter shows up in the very next delivered pixel. It appears as swapped or shifted field bits, and as a wrong `par_err`, one pixel period after the fault. A slot counter that holds the wrong lane count at a pixel boundary corrupts every field of that word, whichever lanes were driven. A wrong idle counter or wake count shows as `standby` rising too early, too late or not at all. It also shows as a discarded word that should have been delivered, which can be seen within one or two pixel periods of the reference stopping or restarting.

// File: rtl/pd_pkg.sv
`timescale 1ns/1ps
package pd_pkg;
  localparam int unsigned WORD_W    = 30;
  localparam int unsigned MAX_LANES = 3;
  localparam int unsigned SLOT_W    = $clog2(WORD_W);
  localparam int unsigned COVER_LO  = 2;

  typedef enum logic [1:0] {
    LM_ONE   = 2'b00,
    LM_TWO   = 2'b01,
    LM_THREE = 2'b10,
    LM_RSVD  = 2'b11
  } lane_mode_e;

  typedef enum logic {
    MON_RUN   = 1'b0,
    MON_SLEEP = 1'b1
  } mon_state_e;

  typedef struct packed {
    logic       par;
    logic       de;
    logic       vs;
    logic       hs;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
    logic [1:0] a;
  } pix_word_t;

  function automatic int unsigned lanes_of(lane_mode_e m);
    case (m)
      LM_TWO:   return 2;
      LM_THREE: return 3;
      default:  return 1;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] last_slot(lane_mode_e m);
    return SLOT_W'(WORD_W / lanes_of(m) - 1);
  endfunction
endpackage

// File: rtl/pd_lane_shifter.sv
`timescale 1ns/1ps
module pd_lane_shifter
  import pd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise_i,
  input  lane_mode_e           mode_i,
  input  logic [MAX_LANES-1:0] lane_i,
  output pix_word_t            word_o,
  output logic                 complete_o
);
  logic [WORD_W-1:0] sr_q, sr_n, shifted;
  logic [SLOT_W-1:0] slot_q, slot_n, cur_slot;
  logic              live_q, live_n, cur_live;
  lane_mode_e        mode_q, mode_n, cur_mode;
  logic [WORD_W-1:0] cand [MAX_LANES];

  // One shift variant per lane count; lane 0 lands in the more significant position
  for (genvar g = 1; g <= MAX_LANES; g++) begin : g_shift
    logic [g-1:0] ins;
    always_comb begin
      for (int k = 0; k < g; k++) ins[g-1-k] = lane_i[k];
    end
    assign cand[g-1] = {sr_q[WORD_W-1-g:0], ins};
  end

  always_comb begin
    cur_live = rise_i | live_q;
    cur_slot = rise_i ? '0 : slot_q;
    cur_mode = rise_i ? mode_i : mode_q;
    case (lanes_of(cur_mode))
      2:       shifted = cand[1];
      3:       shifted = cand[2];
      default: shifted = cand[0];
    endcase
    complete_o = cur_live && (cur_slot == last_slot(cur_mode));
    sr_n   = sr_q;
    slot_n = slot_q;
    live_n = live_q;
    mode_n = mode_q;
    if (cur_live) begin
      sr_n   = shifted;
      slot_n = cur_slot + 1'b1;
      live_n = !complete_o;
      mode_n = cur_mode;
    end
    word_o = pix_word_t'(shifted);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      slot_q <= '0;
      live_q <= 1'b0;
      mode_q <= LM_ONE;
    end else begin
      sr_q   <= sr_n;
      slot_q <= slot_n;
      live_q <= live_n;
      mode_q <= mode_n;
    end
  end

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |=> (slot_q == SLOT_W'(1)));
  assert_mode_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !rise_i) |=> $stable(mode_q));
endmodule

// File: rtl/pd_clk_monitor.sv
`timescale 1ns/1ps
module pd_clk_monitor
  import pd_pkg::*;
#(
  parameter int unsigned LOSS_LIMIT = 64,
  parameter int unsigned WAKE_RISES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_ref_i,
  output logic rise_o,
  output logic standby_o,
  output logic pix_clk_o
);
  localparam int unsigned IDLE_W = $clog2(LOSS_LIMIT + 1);
  localparam int unsigned WAKE_W = $clog2(WAKE_RISES + 1);
  localparam logic [IDLE_W-1:0] LIMIT_V = IDLE_W'(LOSS_LIMIT);
  localparam logic [WAKE_W-1:0] WAKE_LAST = WAKE_W'(WAKE_RISES - 1);

  logic              ref_q;
  logic [IDLE_W-1:0] idle_q, idle_n;
  logic [WAKE_W-1:0] wake_q, wake_n;
  mon_state_e        state_q, state_n;
  logic              quiet, pclk_n;

  always_comb begin
    rise_o  = pix_ref_i & ~ref_q;
    if (rise_o)                idle_n = '0;
    else if (idle_q == LIMIT_V) idle_n = idle_q;
    else                       idle_n = idle_q + 1'b1;
    quiet   = (idle_n == LIMIT_V);
    state_n = state_q;
    wake_n  = wake_q;
    case (state_q)
      MON_RUN: begin
        if (quiet) begin
          state_n = MON_SLEEP;
          wake_n  = '0;
        end
      end
      default: begin
        if (quiet) begin
          wake_n = '0;
        end else if (rise_o) begin
          if (wake_q == WAKE_LAST) begin
            state_n = MON_RUN;
            wake_n  = '0;
          end else begin
            wake_n = wake_q + 1'b1;
          end
        end
      end
    endcase
    pclk_n = pix_ref_i & (state_n == MON_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q     <= 1'b0;
      idle_q    <= '0;
      wake_q    <= '0;
      state_q   <= MON_RUN;
      pix_clk_o <= 1'b0;
    end else begin
      ref_q     <= pix_ref_i;
      idle_q    <= idle_n;
      wake_q    <= wake_n;
      state_q   <= state_n;
      pix_clk_o <= pclk_n;
    end
  end

  assign standby_o = (state_q == MON_SLEEP);

  assert_quiet_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby_o && idle_q == LIMIT_V - 1'b1 && !rise_o) |=> standby_o);
  assert_idle_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q <= LIMIT_V);
  assert_wake_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(standby_o) |-> $past(rise_o));
  assert_clk_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> !pix_clk_o);
endmodule

// File: rtl/pd_word_out.sv
`timescale 1ns/1ps
module pd_word_out
  import pd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              complete_i,
  input  pix_word_t         word_i,
  input  logic              standby_i,
  output logic [WORD_W-2:0] payload_o,
  output logic              par_err_o
);
  logic [WORD_W-2:0] word_q, word_n;
  logic              err_q, err_n, discard_q, discard_n, par_calc;

  always_comb begin
    par_calc  = ^word_i[WORD_W-1:COVER_LO];
    word_n    = word_q;
    err_n     = err_q;
    discard_n = discard_q;
    if (standby_i) begin
      word_n    = '0;
      err_n     = 1'b0;
      discard_n = 1'b1;
    end else if (complete_i) begin
      discard_n = 1'b0;
      if (!discard_q) begin
        word_n = word_i[WORD_W-2:0];
        err_n  = par_calc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= '0;
      err_q     <= 1'b0;
      discard_q <= 1'b1;
    end else begin
      word_q    <= word_n;
      err_q     <= err_n;
      discard_q <= discard_n;
    end
  end

  assign payload_o = word_q;
  assign par_err_o = err_q;

  assert_sleep_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (word_q == '0 && !err_q));
  assert_err_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_q) |-> ($past(complete_i) || $past(standby_i)));
  assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_q) |-> ($past(complete_i) || $past(standby_i)));
endmodule

// File: rtl/pixel_deser.sv
`timescale 1ns/1ps
module pixel_deser
  import pd_pkg::*;
#(
  parameter int unsigned LOSS_LIMIT = 64,
  parameter int unsigned WAKE_RISES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lane_mode,
  input  logic [2:0] lane_data,
  input  logic       pix_ref,
  output logic [7:0] red,
  output logic [7:0] grn,
  output logic [7:0] blu,
  output logic       hsync,
  output logic       vsync,
  output logic       den,
  output logic [1:0] aux,
  output logic       pix_clk_out,
  output logic       par_err,
  output logic       standby
);
  logic              rise, complete;
  pix_word_t         word;
  logic [WORD_W-2:0] payload;

  pd_clk_monitor #(
    .LOSS_LIMIT(LOSS_LIMIT),
    .WAKE_RISES(WAKE_RISES)
  ) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_ref_i (pix_ref),
    .rise_o    (rise),
    .standby_o (standby),
    .pix_clk_o (pix_clk_out)
  );

  pd_lane_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (rise),
    .mode_i     (lane_mode_e'(lane_mode)),
    .lane_i     (lane_data),
    .word_o     (word),
    .complete_o (complete)
  );

  pd_word_out u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .complete_i (complete),
    .word_i     (word),
    .standby_i  (standby),
    .payload_o  (payload),
    .par_err_o  (par_err)
  );

  assign {den, vsync, hsync, red, grn, blu, aux} = payload;
endmodule

// File: tb/test_pixel_deser.sv
`timescale 1ns/1ps
module test_pixel_deser;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] lane_mode;
  logic [2:0] lane_data;
  logic       pix_ref;
  logic [7:0] red, grn, blu;
  logic       hsync, vsync, den, pix_clk_out, par_err, standby;
  logic [1:0] aux;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pixel_deser i_pixel_deser (
    .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode), .lane_data(lane_data),
    .pix_ref(pix_ref), .red(red), .grn(grn), .blu(blu), .hsync(hsync),
    .vsync(vsync), .den(den), .aux(aux), .pix_clk_out(pix_clk_out),
    .par_err(par_err), .standby(standby)
  );

  // {mode[31:30], bad_parity[29], de vs hs r g b [28:2], aux[1:0]}
  localparam logic [31:0] VEC [9] = '{
    {2'b00, 1'b0, 3'b101, 24'hA53C0F, 2'b10},
    {2'b00, 1'b1, 3'b010, 24'hFF0000, 2'b01},
    {2'b01, 1'b0, 3'b111, 24'h00FF00, 2'b11},
    {2'b01, 1'b1, 3'b000, 24'h0000FF, 2'b00},
    {2'b10, 1'b0, 3'b110, 24'hC3817E, 2'b01},
    {2'b10, 1'b1, 3'b001, 24'hFFFFFF, 2'b11},
    {2'b11, 1'b0, 3'b011, 24'h5A5A5A, 2'b10},
    {2'b10, 1'b0, 3'b101, 24'hA53C0F, 2'b01},
    {2'b00, 1'b0, 3'b000, 24'h000000, 2'b11}
  };

  function automatic logic [29:0] mk_word(logic [31:0] v);
    return {(^v[28:2]) ^ v[29], v[28:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req, logic [28:0] exp_pl, logic exp_err);
    chk(req, 32'({den, vsync, hsync, red, grn, blu, aux}), 32'(exp_pl));
    chk(req, 32'(par_err), 32'(exp_err));
  endtask

  // Drives one pixel; returns at the negedge after its last slot with pix_ref low
  task automatic send_pixel(logic [1:0] mode, logic [29:0] w, int stop_after,
                            logic [1:0] alt_mode);
    int n;
    int per;
    n   = (mode == 2'b01) ? 2 : (mode == 2'b10) ? 3 : 1;
    per = 30 / n;
    for (int s = 0; s < per && s < stop_after; s++) begin
      @(negedge clk);
      pix_ref   = (s < per / 2);
      lane_mode = (s >= 2) ? alt_mode : mode;
      for (int k = 0; k < 3; k++)
        lane_data[k] = (k < n) ? w[29 - (s * n + k)] : 1'b0;
    end
    @(negedge clk);
    pix_ref = 1'b0;
  endtask

  task automatic send_vec(int i);
    send_pixel(VEC[i][31:30], mk_word(VEC[i]), 99, VEC[i][31:30]);
  endtask

  task automatic idle(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      pix_ref = 1'b0;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lane_mode = 2'b00; lane_data = '0; pix_ref = 1'b0;
    repeat (4) @(negedge clk);
    chk_out("R1 reset fields", '0, 1'b0);
    chk("R1 reset standby", 32'(standby), 0);
    chk("R1 reset pix_clk", 32'(pix_clk_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_out("R1 after release", '0, 1'b0);

    // R9: first word after reset is dropped
    send_vec(0);
    chk_out("R9 first word after reset discarded", '0, 1'b0);

    // Table walk: R2 lane slicing, R5 parity, aux exclusion
    for (int i = 0; i < 9; i++) begin
      send_vec(i);
      chk_out($sformatf("R2 R5 vector %0d", i), VEC[i][28:0], VEC[i][29]);
    end

    // R4: hold between pixels, error flag lasts one pixel
    send_vec(1);
    idle(20);
    chk_out("R4 bad pixel held while idle", VEC[1][28:0], 1'b1);
    send_vec(0);
    chk_out("R4 good pixel clears flag", VEC[0][28:0], 1'b0);

    // R6: partial word dropped on restart
    send_pixel(VEC[2][31:30], mk_word(VEC[2]), 4, VEC[2][31:30]);
    send_vec(4);
    chk_out("R6 restart drops partial", VEC[4][28:0], 1'b0);

    // R3: mode change mid-pixel ignored
    send_pixel(VEC[0][31:30], mk_word(VEC[0]), 99, 2'b10);
    chk_out("R3 mode latched one lane", VEC[0][28:0], 1'b0);
    send_pixel(VEC[5][31:30], mk_word(VEC[5]), 99, 2'b00);
    chk_out("R3 mode latched three lanes", VEC[5][28:0], 1'b1);

    // R10: regenerated clock follows reference by one cycle
    @(negedge clk); pix_ref = 1'b1;
    @(negedge clk);
    chk("R10 pix_clk high", 32'(pix_clk_out), 1);
    pix_ref = 1'b0;
    @(negedge clk);
    chk("R10 pix_clk low", 32'(pix_clk_out), 0);
    send_vec(3);
    chk_out("R6 word after clock probe", VEC[3][28:0], 1'b1);

    // R7: standby on quiet reference
    idle(40);
    chk("R7 still active before limit", 32'(standby), 0);
    chk_out("R7 outputs held before limit", VEC[3][28:0], 1'b1);
    idle(30);
    chk("R7 standby after quiet", 32'(standby), 1);
    chk_out("R7 outputs blanked", '0, 1'b0);
    chk("R7 pix_clk gated", 32'(pix_clk_out), 0);

    // R8 / R9: wake on third edge, that pixel dropped
    send_vec(0);
    chk("R8 standby after one edge", 32'(standby), 1);
    chk_out("R7 blank during wake", '0, 1'b0);
    send_vec(1);
    chk("R8 standby after two edges", 32'(standby), 1);
    send_vec(2);
    chk("R8 wake after third edge", 32'(standby), 0);
    chk_out("R9 first word after wake discarded", '0, 1'b0);
    send_vec(4);
    chk_out("R9 second word after wake delivered", VEC[4][28:0], 1'b0);

    // R8: quiet gap during standby restarts edge count
    idle(80);
    chk("R7 standby again", 32'(standby), 1);
    send_vec(0);
    send_vec(1);
    idle(80);
    send_vec(2);
    chk("R8 count restarted one edge", 32'(standby), 1);
    send_vec(4);
    chk("R8 count restarted two edges", 32'(standby), 1);
    send_vec(5);
    chk("R8 wake after restarted count", 32'(standby), 0);
    chk_out("R9 discard after second wake", '0, 1'b0);
    send_vec(6);
    chk_out("R2 reserved mode after wake", VEC[6][28:0], 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule